// File: doc/BRIEF.md
# Split-Channel Network Interface Buffer Manager

This block sits between a node's local processor port and its network port. It carries one-way network transactions in both directions. Requests and replies travel on logically separate channels. Each channel has its own outbound queue, fed from the local side, and its own inbound queue, drained by the local consumer. The result is that congestion on one kind of traffic never holds up the other.

Inbound buffer space is reserved ahead of time. Every other node owns K credited slots in the inbound request queue, and the inbound response queue holds K entries for answers to this node's own requests. The local side may not have more than K requests in flight. Because of these bounds, the network input never needs to push back: it accepts a transaction on every cycle. A request that finds its sender's credits used up is not stored. Instead the block turns it into a negative acknowledgement (NACK) addressed back to the sender. Outbound NACKs are served ahead of every other outbound transaction.

A transaction carries a 2-bit kind code, a node number and a payload. The kind codes are 0 for a request, 1 for a reply and 2 for a NACK; inbound code 3 is discarded. On the network input the node number names the sender. On the network output it names the destination. The block does no routing and no address checking.

Top module: `nif_buffer_mgr`

## Requirements
- R1: The request and reply channels are independent. A full inbound response queue does not stop an inbound request from being delivered on the request consumer port. A full outbound request queue does not stop the local reply port from accepting.
- R2: `nin_ready` is high in every cycle, including cycles where the network output is stalled and the outbound queues are full.
- R3: The count of outstanding local requests never exceeds K. `lreq_ready` is low whenever K requests are outstanding.
- R4: Each sender other than this node has K inbound request credits. An inbound request (kind 0) is stored only if its sender holds fewer than K entries in the inbound request queue. A sender's credit returns only when the local consumer takes that sender's entry. A request carrying this node's own number is never stored.
- R5: A request that is not stored produces an outbound NACK. The NACK has kind 2, the destination is the rejected sender, and the payload is the rejected request's payload.
- R6: The network output always presents a pending NACK first, then a local reply, then a local request. While `nout_valid` is high and `nout_ready` is low, `nout_valid` stays high.
- R7: Inbound replies (kind 1) and NACKs (kind 2) go to the response consumer port, with `crsp_kind` giving the code. Taking one there lowers the outstanding count by one. When the count is zero it stays at zero.
- R8: After reset all queues are empty, all credits are free and the outstanding count is zero. All valid outputs are low, and `lreq_ready`, `lrsp_ready` and `nin_ready` are high.
- R9: Each queue keeps first-in first-out order. The consumer and network ports present each entry's kind, node and payload unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lreq_valid | input | 1 | Local request offered |
| lreq_ready | output | 1 | Local request taken |
| lreq_node | input | clog2(P) | Destination of the local request |
| lreq_data | input | DW | Payload of the local request |
| lrsp_valid | input | 1 | Local reply offered |
| lrsp_ready | output | 1 | Local reply taken |
| lrsp_node | input | clog2(P) | Destination of the local reply |
| lrsp_data | input | DW | Payload of the local reply |
| nout_valid | output | 1 | Outbound network transaction present |
| nout_ready | input | 1 | Network takes the outbound transaction |
| nout_kind | output | 2 | Outbound kind: 0 request, 1 reply, 2 NACK |
| nout_node | output | clog2(P) | Outbound destination node |
| nout_data | output | DW | Outbound payload |
| nin_valid | input | 1 | Inbound network transaction present |
| nin_ready | output | 1 | Inbound transaction taken (always high) |
| nin_kind | input | 2 | Inbound kind code |
| nin_node | input | clog2(P) | Inbound sender node |
| nin_data | input | DW | Inbound payload |
| creq_valid | output | 1 | Stored inbound request available |
| creq_ready | input | 1 | Local consumer takes the request |
| creq_node | output | clog2(P) | Sender of the request |
| creq_data | output | DW | Payload of the request |
| crsp_valid | output | 1 | Stored inbound reply or NACK available |
| crsp_ready | input | 1 | Local consumer takes the response |
| crsp_kind | output | 2 | 1 for a reply, 2 for a NACK |
| crsp_node | output | clog2(P) | Sender of the response |
| crsp_data | output | DW | Payload of the response |

## Verification
The bench builds the block with P=4, K=2, an 8-bit payload and node number 0. This gives a six-entry inbound request queue, split into three two-credit senders, and two-entry outbound and response queues. With these sizes a few transactions are enough to fill the credits of one sender while leaving room for the others. They are also enough to reach the K-outstanding stall and to fill both outbound queues. At that point all three outbound sources compete at once and their presentation order becomes visible. The small node count also means the own-number case and the credit return after a consumer pop can both be reached within short directed sequences.

// File: rtl/nif_pkg.sv
package nif_pkg;

    typedef enum logic [1:0] {
        MK_REQ = 2'd0,
        MK_RSP = 2'd1,
        MK_NAK = 2'd2,
        MK_BAD = 2'd3
    } msg_kind_e;

    function automatic int unsigned id_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/nif_fifo.sv
module nif_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = nif_pkg::id_width(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;

    wire do_push = push && !full;
    wire do_pop  = pop && !empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (do_pop)
                rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)
                fill <= fill + CW'(1);
            else if (do_pop && !do_push)
                fill <= fill - CW'(1);
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (fill == '0);
    assign full  = (fill == CW'(DEPTH));
endmodule

// File: rtl/nif_credit_tbl.sv
module nif_credit_tbl #(
    parameter int unsigned P       = 4,
    parameter int unsigned K       = 2,
    parameter int unsigned NODE_ID = 0,
    localparam int unsigned IDW    = nif_pkg::id_width(P),
    localparam int unsigned CNTW   = $clog2(K + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [IDW-1:0] chk_id,
    output logic           chk_ok,
    input  logic           take,
    input  logic [IDW-1:0] take_id,
    input  logic           give,
    input  logic [IDW-1:0] give_id
);
    logic [CNTW-1:0] held [P];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < P; n++) held[n] <= '0;
        end else begin
            for (int n = 0; n < P; n++) begin
                if (take && take_id == IDW'(n) && !(give && give_id == IDW'(n)))
                    held[n] <= held[n] + CNTW'(1);
                else if (give && give_id == IDW'(n) && !(take && take_id == IDW'(n))
                         && held[n] != '0)
                    held[n] <= held[n] - CNTW'(1);
            end
        end
    end

    always_comb begin
        chk_ok = 1'b0;
        if (int'(chk_id) < P && chk_id != IDW'(NODE_ID))
            chk_ok = (held[chk_id] < CNTW'(K));
    end
endmodule

// File: rtl/nif_issue_limit.sv
module nif_issue_limit #(
    parameter int unsigned K    = 2,
    localparam int unsigned CNTW = $clog2(K + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            inc,
    input  logic            dec,
    output logic [CNTW-1:0] count,
    output logic            room
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (inc && !dec)
            count <= count + CNTW'(1);
        else if (dec && !inc && count != '0)
            count <= count - CNTW'(1);
    end

    assign room = (count < CNTW'(K));
endmodule

// File: rtl/nif_out_arb.sv
module nif_out_arb
    import nif_pkg::*;
#(
    parameter int unsigned IDW = 2,
    parameter int unsigned DW  = 8
) (
    input  logic           nak_v,
    input  logic [IDW-1:0] nak_node,
    input  logic [DW-1:0]  nak_data,
    input  logic           rsp_v,
    input  logic [IDW-1:0] rsp_node,
    input  logic [DW-1:0]  rsp_data,
    input  logic           req_v,
    input  logic [IDW-1:0] req_node,
    input  logic [DW-1:0]  req_data,
    input  logic           out_ready,
    output logic           out_valid,
    output logic [1:0]     out_kind,
    output logic [IDW-1:0] out_node,
    output logic [DW-1:0]  out_data,
    output logic           nak_pop,
    output logic           rsp_pop,
    output logic           req_pop
);
    always_comb begin
        out_valid = nak_v || rsp_v || req_v;
        nak_pop   = 1'b0;
        rsp_pop   = 1'b0;
        req_pop   = 1'b0;
        if (nak_v) begin
            out_kind = MK_NAK;
            out_node = nak_node;
            out_data = nak_data;
            nak_pop  = out_ready;
        end else if (rsp_v) begin
            out_kind = MK_RSP;
            out_node = rsp_node;
            out_data = rsp_data;
            rsp_pop  = out_ready;
        end else begin
            out_kind = MK_REQ;
            out_node = req_node;
            out_data = req_data;
            req_pop  = out_ready && req_v;
        end
    end
endmodule

// File: rtl/nif_buffer_mgr.sv
module nif_buffer_mgr
    import nif_pkg::*;
#(
    parameter int unsigned P       = 4,
    parameter int unsigned K       = 2,
    parameter int unsigned DW      = 8,
    parameter int unsigned NODE_ID = 0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     lreq_valid,
    output logic                     lreq_ready,
    input  logic [id_width(P)-1:0]   lreq_node,
    input  logic [DW-1:0]            lreq_data,
    input  logic                     lrsp_valid,
    output logic                     lrsp_ready,
    input  logic [id_width(P)-1:0]   lrsp_node,
    input  logic [DW-1:0]            lrsp_data,
    output logic                     nout_valid,
    input  logic                     nout_ready,
    output logic [1:0]               nout_kind,
    output logic [id_width(P)-1:0]   nout_node,
    output logic [DW-1:0]            nout_data,
    input  logic                     nin_valid,
    output logic                     nin_ready,
    input  logic [1:0]               nin_kind,
    input  logic [id_width(P)-1:0]   nin_node,
    input  logic [DW-1:0]            nin_data,
    output logic                     creq_valid,
    input  logic                     creq_ready,
    output logic [id_width(P)-1:0]   creq_node,
    output logic [DW-1:0]            creq_data,
    output logic                     crsp_valid,
    input  logic                     crsp_ready,
    output logic [1:0]               crsp_kind,
    output logic [id_width(P)-1:0]   crsp_node,
    output logic [DW-1:0]            crsp_data
);
    localparam int unsigned IDW       = id_width(P);
    localparam int unsigned CNTW      = $clog2(K + 1);
    localparam int unsigned EW        = IDW + DW;
    localparam int unsigned REQ_SLOTS = K * (P - 1);
    localparam int unsigned RSP_SLOTS = K;
    localparam int unsigned NAK_SLOTS = K * (P - 1);
    localparam int unsigned OUT_SLOTS = K;

    // ---------------- outbound request channel ----------------
    logic            issue_room;
    logic [CNTW-1:0] issued_cnt;
    logic            rqo_empty, rqo_full, rqo_pop;
    logic [EW-1:0]   rqo_head;
    wire             lreq_fire = lreq_valid && lreq_ready;

    assign lreq_ready = issue_room && !rqo_full;

    nif_fifo #(.W(EW), .DEPTH(OUT_SLOTS)) u_req_out (
        .clk(clk), .rst(rst),
        .push(lreq_fire), .din({lreq_node, lreq_data}),
        .pop(rqo_pop), .dout(rqo_head),
        .empty(rqo_empty), .full(rqo_full)
    );

    // ---------------- outbound reply channel -------------------
    logic          rpo_empty, rpo_full, rpo_pop;
    logic [EW-1:0] rpo_head;

    assign lrsp_ready = !rpo_full;

    nif_fifo #(.W(EW), .DEPTH(OUT_SLOTS)) u_rsp_out (
        .clk(clk), .rst(rst),
        .push(lrsp_valid && lrsp_ready), .din({lrsp_node, lrsp_data}),
        .pop(rpo_pop), .dout(rpo_head),
        .empty(rpo_empty), .full(rpo_full)
    );

    // ---------------- inbound classification -------------------
    logic credit_ok;
    wire  in_req    = nin_valid && (nin_kind == MK_REQ);
    wire  in_rsp    = nin_valid && (nin_kind == MK_RSP || nin_kind == MK_NAK);
    wire  req_store = in_req && credit_ok;
    wire  req_deny  = in_req && !credit_ok;

    assign nin_ready = 1'b1;

    // ---------------- NACK queue --------------------------------
    logic          nak_empty, nak_full, nak_pop;
    logic [EW-1:0] nak_head;

    nif_fifo #(.W(EW), .DEPTH(NAK_SLOTS)) u_nak_out (
        .clk(clk), .rst(rst),
        .push(req_deny && !nak_full), .din({nin_node, nin_data}),
        .pop(nak_pop), .dout(nak_head),
        .empty(nak_empty), .full(nak_full)
    );

    // ---------------- inbound request queue + credits ----------
    logic          rqi_empty, rqi_full;
    logic [EW-1:0] rqi_head;
    wire           creq_fire = creq_valid && creq_ready;

    nif_credit_tbl #(.P(P), .K(K), .NODE_ID(NODE_ID)) u_credit (
        .clk(clk), .rst(rst),
        .chk_id(nin_node), .chk_ok(credit_ok),
        .take(req_store), .take_id(nin_node),
        .give(creq_fire), .give_id(creq_node)
    );

    nif_fifo #(.W(EW), .DEPTH(REQ_SLOTS)) u_req_in (
        .clk(clk), .rst(rst),
        .push(req_store), .din({nin_node, nin_data}),
        .pop(creq_fire), .dout(rqi_head),
        .empty(rqi_empty), .full(rqi_full)
    );

    assign creq_valid = !rqi_empty;
    assign {creq_node, creq_data} = rqi_head;

    // ---------------- inbound response queue --------------------
    logic            rsi_empty, rsi_full;
    logic [EW:0]     rsi_head;
    wire             crsp_fire = crsp_valid && crsp_ready;

    nif_fifo #(.W(EW + 1), .DEPTH(RSP_SLOTS)) u_rsp_in (
        .clk(clk), .rst(rst),
        .push(in_rsp && !rsi_full),
        .din({nin_kind == MK_NAK, nin_node, nin_data}),
        .pop(crsp_fire), .dout(rsi_head),
        .empty(rsi_empty), .full(rsi_full)
    );

    assign crsp_valid = !rsi_empty;
    assign crsp_kind  = rsi_head[EW] ? MK_NAK : MK_RSP;
    assign {crsp_node, crsp_data} = rsi_head[EW-1:0];

    nif_issue_limit #(.K(K)) u_limit (
        .clk(clk), .rst(rst),
        .inc(lreq_fire), .dec(crsp_fire),
        .count(issued_cnt), .room(issue_room)
    );

    // ---------------- network output arbitration -------------
    nif_out_arb #(.IDW(IDW), .DW(DW)) u_arb (
        .nak_v(!nak_empty), .nak_node(nak_head[EW-1:DW]), .nak_data(nak_head[DW-1:0]),
        .rsp_v(!rpo_empty), .rsp_node(rpo_head[EW-1:DW]), .rsp_data(rpo_head[DW-1:0]),
        .req_v(!rqo_empty), .req_node(rqo_head[EW-1:DW]), .req_data(rqo_head[DW-1:0]),
        .out_ready(nout_ready),
        .out_valid(nout_valid), .out_kind(nout_kind),
        .out_node(nout_node), .out_data(nout_data),
        .nak_pop(nak_pop), .rsp_pop(rpo_pop), .req_pop(rqo_pop)
    );
endmodule

// File: rtl/nif_buffer_mgr_chk.sv
module nif_buffer_mgr_chk #(
    parameter int unsigned K    = 2,
    parameter int unsigned CNTW = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            lreq_valid,
    input logic            lreq_ready,
    input logic            nout_valid,
    input logic            nout_ready,
    input logic [1:0]      nout_kind,
    input logic            crsp_valid,
    input logic            crsp_ready,
    input logic [CNTW-1:0] issued_cnt,
    input logic            nak_pending
);
    assert_count_cap_R3: assert property (@(posedge clk) disable iff (rst)
        issued_cnt <= CNTW'(K));

    assert_stall_at_limit_R3: assert property (@(posedge clk) disable iff (rst)
        (issued_cnt == CNTW'(K)) |-> !lreq_ready);

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (nout_valid && !nout_ready) |=> nout_valid);

    assert_nak_first_R6: assert property (@(posedge clk) disable iff (rst)
        nak_pending |-> (nout_valid && nout_kind == 2'd2));

    assert_consume_dec_R7: assert property (@(posedge clk) disable iff (rst)
        (crsp_valid && crsp_ready && issued_cnt != '0 && !(lreq_valid && lreq_ready))
        |=> issued_cnt == $past(issued_cnt) - CNTW'(1));
endmodule

bind nif_buffer_mgr nif_buffer_mgr_chk #(.K(K), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst(rst),
    .lreq_valid(lreq_valid), .lreq_ready(lreq_ready),
    .nout_valid(nout_valid), .nout_ready(nout_ready), .nout_kind(nout_kind),
    .crsp_valid(crsp_valid), .crsp_ready(crsp_ready),
    .issued_cnt(issued_cnt), .nak_pending(!nak_empty)
);

// File: tb/tb_nif_buffer_mgr.sv
`timescale 1ns/1ps
module tb_nif_buffer_mgr;
    localparam int unsigned P = 4;
    localparam int unsigned K = 2;
    localparam int unsigned DW = 8;
    localparam int unsigned IDW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic lreq_valid = 0, lreq_ready;  logic [IDW-1:0] lreq_node = 0; logic [DW-1:0] lreq_data = 0;
    logic lrsp_valid = 0, lrsp_ready;  logic [IDW-1:0] lrsp_node = 0; logic [DW-1:0] lrsp_data = 0;
    logic nout_valid, nout_ready = 0;  logic [1:0] nout_kind; logic [IDW-1:0] nout_node; logic [DW-1:0] nout_data;
    logic nin_valid = 0, nin_ready;    logic [1:0] nin_kind = 0; logic [IDW-1:0] nin_node = 0; logic [DW-1:0] nin_data = 0;
    logic creq_valid, creq_ready = 0;  logic [IDW-1:0] creq_node; logic [DW-1:0] creq_data;
    logic crsp_valid, crsp_ready = 0;  logic [1:0] crsp_kind; logic [IDW-1:0] crsp_node; logic [DW-1:0] crsp_data;

    nif_buffer_mgr #(.P(P), .K(K), .DW(DW), .NODE_ID(0)) dut (.*);

    int checks = 0;
    int errors = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic net_in(input logic [1:0] kind, input logic [IDW-1:0] src, input logic [DW-1:0] d);
        nin_valid = 1'b1; nin_kind = kind; nin_node = src; nin_data = d;
        step();
        nin_valid = 1'b0;
    endtask

    task automatic issue_req(input logic [IDW-1:0] dst, input logic [DW-1:0] d);
        lreq_valid = 1'b1; lreq_node = dst; lreq_data = d;
        step();
        lreq_valid = 1'b0;
    endtask

    task automatic issue_rsp(input logic [IDW-1:0] dst, input logic [DW-1:0] d);
        lrsp_valid = 1'b1; lrsp_node = dst; lrsp_data = d;
        step();
        lrsp_valid = 1'b0;
    endtask

    task automatic take_out();
        nout_ready = 1'b1; step(); nout_ready = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [1:0] kind,
                              input logic [IDW-1:0] node, input logic [DW-1:0] d);
        check(req, {31'd0, nout_valid}, 32'd1);
        check(req, {30'd0, nout_kind}, {30'd0, kind});
        check(req, {30'd0, nout_node}, {30'd0, node});
        check(req, {24'd0, nout_data}, {24'd0, d});
        take_out();
    endtask

    typedef struct packed {
        logic [IDW-1:0] src;
        logic [DW-1:0]  data;
        logic           nak;
    } vec_t;

    // Inbound requests with the consumer stalled: sender credits K=2, own node 0 refused.
    localparam vec_t VECS [10] = '{
        '{2'd1, 8'h11, 1'b0}, '{2'd1, 8'h12, 1'b0}, '{2'd1, 8'h13, 1'b1},
        '{2'd2, 8'h21, 1'b0}, '{2'd3, 8'h31, 1'b0}, '{2'd2, 8'h22, 1'b0},
        '{2'd2, 8'h23, 1'b1}, '{2'd3, 8'h32, 1'b0}, '{2'd3, 8'h33, 1'b1},
        '{2'd0, 8'h01, 1'b1}
    };

    localparam logic [IDW+DW-1:0] POP_ORDER [6] = '{
        {2'd1, 8'h12}, {2'd2, 8'h21}, {2'd3, 8'h31},
        {2'd2, 8'h22}, {2'd3, 8'h32}, {2'd1, 8'h14}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R8 reset state
        check("R8 nout_valid", {31'd0, nout_valid}, 32'd0);
        check("R8 creq_valid", {31'd0, creq_valid}, 32'd0);
        check("R8 crsp_valid", {31'd0, crsp_valid}, 32'd0);
        check("R8 lreq_ready", {31'd0, lreq_ready}, 32'd1);
        check("R8 lrsp_ready", {31'd0, lrsp_ready}, 32'd1);
        check("R8 nin_ready",  {31'd0, nin_ready},  32'd1);

        // R4 / R5 / R2: vector table walk
        for (int i = 0; i < 10; i++) begin
            check("R2 nin_ready", {31'd0, nin_ready}, 32'd1);
            net_in(2'd0, VECS[i].src, VECS[i].data);
            if (VECS[i].nak)
                expect_out("R5 nack", 2'd2, VECS[i].src, VECS[i].data);
            else
                check("R4 stored no nack", {31'd0, nout_valid}, 32'd0);
        end

        // R9 first entry, then R4 credit return
        check("R9 creq head", {22'd0, creq_node, creq_data}, {22'd0, 2'd1, 8'h11});
        creq_ready = 1'b1; step(); creq_ready = 1'b0;
        net_in(2'd0, 2'd1, 8'h14);
        check("R4 credit returned", {31'd0, nout_valid}, 32'd0);
        for (int i = 0; i < 6; i++) begin
            check("R9 creq order", {22'd0, creq_valid ? {creq_node, creq_data} : 10'h3ff},
                  {22'd0, POP_ORDER[i]});
            creq_ready = 1'b1; step(); creq_ready = 1'b0;
        end
        check("R9 creq drained", {31'd0, creq_valid}, 32'd0);

        // R3 / R7: outstanding limit
        do_reset();
        nout_ready = 1'b1;
        check("R3 ready at 0", {31'd0, lreq_ready}, 32'd1);
        issue_req(2'd2, 8'hA1);
        check("R9 request out", {20'd0, nout_valid, nout_kind, nout_node, nout_data},
              {20'd0, 1'b1, 2'd0, 2'd2, 8'hA1});
        issue_req(2'd3, 8'hA2);
        check("R3 stall at K", {31'd0, lreq_ready}, 32'd0);
        lreq_valid = 1'b1; lreq_data = 8'hA3;
        step(); step();
        lreq_valid = 1'b0;
        check("R3 no third request", {31'd0, nout_valid}, 32'd0);
        nout_ready = 1'b0;

        net_in(2'd1, 2'd2, 8'hB1);
        check("R7 reply delivered", {20'd0, crsp_valid, crsp_kind, crsp_node, crsp_data},
              {20'd0, 1'b1, 2'd1, 2'd2, 8'hB1});
        check("R7 not freed before take", {31'd0, lreq_ready}, 32'd0);
        check("R1 reply not in request queue", {31'd0, creq_valid}, 32'd0);
        crsp_ready = 1'b1; step(); crsp_ready = 1'b0;
        check("R7 freed after take", {31'd0, lreq_ready}, 32'd1);
        net_in(2'd2, 2'd3, 8'hB2);
        check("R7 nack delivered", {28'd0, crsp_kind, crsp_node}, {28'd0, 2'd2, 2'd3});
        crsp_ready = 1'b1; step(); crsp_ready = 1'b0;
        net_in(2'd1, 2'd1, 8'hB3);
        crsp_ready = 1'b1; step(); crsp_ready = 1'b0;
        nout_ready = 1'b1;
        issue_req(2'd1, 8'hA4);
        issue_req(2'd1, 8'hA5);
        check("R7 no underflow, stall at K", {31'd0, lreq_ready}, 32'd0);
        step();
        nout_ready = 1'b0;

        // R1 / R2 / R6: independence and output priority
        do_reset();
        issue_req(2'd3, 8'hD1);
        issue_req(2'd3, 8'hD2);
        check("R1 reply port open", {31'd0, lrsp_ready}, 32'd1);
        issue_rsp(2'd1, 8'hC1);
        issue_rsp(2'd2, 8'hC2);
        check("R2 nin_ready with output stalled", {31'd0, nin_ready}, 32'd1);
        net_in(2'd1, 2'd1, 8'hE1);
        net_in(2'd1, 2'd2, 8'hE2);
        net_in(2'd0, 2'd2, 8'h55);
        check("R1 request beside full responses", {21'd0, creq_valid, creq_node, creq_data},
              {21'd0, 1'b1, 2'd2, 8'h55});
        net_in(2'd0, 2'd0, 8'h77);
        expect_out("R6 nack first", 2'd2, 2'd0, 8'h77);
        expect_out("R6 reply second", 2'd1, 2'd1, 8'hC1);
        expect_out("R9 reply order", 2'd1, 2'd2, 8'hC2);
        expect_out("R6 request last", 2'd0, 2'd3, 8'hD1);
        expect_out("R9 request order", 2'd0, 2'd3, 8'hD2);
        check("R6 output empty", {31'd0, nout_valid}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule